// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt events for a small processor core and turns them into a single request line with a vector number. It has one non-maskable input, fed by the watchdog timer, and a set of maskable sources. By default there are 52 maskable sources: 44 come from on-chip peripherals as single-cycle strobes and 8 come from external pins. Each maskable source keeps a pending flag and has an enable bit and a 2-bit priority field. The enable and priority settings are presented as static configuration inputs.

Each external pin first passes through a two-flop synchronizer. An optional filter can then require the pin level to hold steady for three ticks of a slow sample strobe. After that, an edge selector picks rising, falling, both or no edges. On every clock the arbiter looks at the pending state for the next cycle. The non-maskable source always wins. Otherwise the arbiter picks the pending, enabled source with the highest rank that also beats the core's current level. The result is registered onto the request and vector outputs. An acknowledge clears the pending flag of the source that is currently shown on the outputs.

Top module: `prio_intc`

## Requirements
- R1: While reset is high, and on the first cycle after it, `irq_req_o` is 0 and `irq_vec_o` is 0, with all pending state cleared.
- R2: Vector numbering is as follows: the watchdog source is vector 0; internal source k is vector k+1; external pin j is vector N_INT+j+1. A strobe on an enabled internal source, with nothing else pending, produces that vector.
- R3: A source whose enable bit is 0 still latches its pending flag but is never forwarded. Once the enable bit is set, the source is forwarded.
- R4: A source's rank is its 2-bit priority field plus one, giving ranks 1 to 4. Among eligible sources, the highest rank is forwarded.
- R5: Among eligible sources of equal rank, the lowest source index is forwarded.
- R6: A maskable source is forwarded only if its rank is strictly greater than `cpu_lvl_i`. A value of 4 or more on `cpu_lvl_i` blocks every maskable source.
- R7: A pending watchdog event is always forwarded as vector 0, whatever the enables, priority fields and `cpu_lvl_i`.
- R8: `ack_i` clears the pending flag of the source shown on `irq_vec_o` while `irq_req_o` is 1. The next winner appears after that same clock edge.
- R9: If a new event for the acknowledged source arrives in the acknowledge cycle, the source stays pending.
- R10: The edge selector for each pin is 2 bits: 00 ignores the pin, 01 takes rising edges, 10 takes falling edges and 11 takes both. With the filter off, the pin passes only through a 2-flop synchronizer.
- R11: With the filter on, the filtered level changes only after the synchronized pin has shown the same new value on 3 consecutive sample ticks. Pulses shorter than that produce no event.
- R12: The outputs are registered from next-state pending logic. An internal strobe sampled at a clock edge is visible on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_nmi_i | input | 1 | Watchdog non-maskable event strobe |
| int_evt_i | input | 44 | Internal source event strobes |
| ext_pin_i | input | 8 | Asynchronous external pins |
| sample_tick_i | input | 1 | Sample strobe for the pin filters |
| ext_edge_sel_i | input | 16 | 2-bit edge selection per pin |
| ext_filt_en_i | input | 8 | Filter enable per pin |
| src_en_i | input | 52 | Enable bit per maskable source |
| src_lvl_i | input | 104 | 2-bit priority field per maskable source |
| cpu_lvl_i | input | 3 | Current level of the core (0 to 4) |
| ack_i | input | 1 | Acknowledge of the shown vector |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 6 | Vector number of the request |

## Verification
Arbitration is driven with pairs of pending sources. In one pair the higher rank sits at the higher index, which separates rank ordering from index ordering. In another pair the ranks are equal, which shows the tie-break alone. The current level is swept across the rank of a single pending source, which exposes an off-by-one between strict and non-strict comparison. The watchdog is raised while everything else is masked. External pins are toggled under each of the four edge settings and both filter modes, so a swapped edge code or a filter that accepts two ticks shows up as a wrong vector or an unexpected request.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int LVL_W = 2;  // priority field width per source
  localparam int CUR_W = 3;  // width of the core's current level

endpackage

// File: rtl/prio_intc_ext_cond.sv
module prio_intc_ext_cond
  import prio_intc_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       tick_i,
  input  logic       filt_en_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic [FILT_LEN-1:0] hist_nxt;
  logic                filt_q;
  logic                prev_q;
  logic                cur;

  assign hist_nxt = {hist_q[FILT_LEN-2:0], sync_q[1]};
  assign cur      = filt_en_i ? filt_q : sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= cur;
      if (tick_i) begin
        hist_q <= hist_nxt;
        if (&hist_nxt)       filt_q <= 1'b1;
        else if (~|hist_nxt) filt_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (edge_mode_e'(edge_sel_i))
      EDGE_RISE: hit_o = cur & ~prev_q;
      EDGE_FALL: hit_o = ~cur & prev_q;
      EDGE_BOTH: hit_o = cur ^ prev_q;
      default:   hit_o = 1'b0;
    endcase
  end

  // R11: filtered level rises only after FILT_LEN high tick samples
  a_r11_three_ticks: assert property (@(posedge clk) disable iff (rst)
    $rose(filt_q) |-> ($past(tick_i) && (&$past(hist_q[FILT_LEN-2:0])) && $past(sync_q[1])));

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = 52,
  parameter int VW    = 6
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [LVL_W*N_SRC-1:0] lvl_i,
  input  logic [CUR_W-1:0]       cpu_lvl_i,
  input  logic                   nmi_i,
  output logic                   req_o,
  output logic [VW-1:0]          vec_o
);

  logic [CUR_W-1:0] best_rank;
  logic [CUR_W-1:0] rank;
  logic [VW-1:0]    best_vec;
  logic             hit;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    best_rank = '0;
    best_vec  = '0;
    hit       = 1'b0;
    rank      = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      rank = {1'b0, lvl_i[LVL_W*i +: LVL_W]} + CUR_W'(1);
      if (pend_i[i] && en_i[i] && (rank > cpu_lvl_i) && (rank >= best_rank)) begin
        best_rank = rank;
        best_vec  = VW'(i + 1);
        hit       = 1'b1;
      end
    end
    req_o = nmi_i | hit;
    vec_o = nmi_i ? '0 : best_vec;
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_INT    = 44,
  parameter int N_EXT    = 8,
  parameter int FILT_LEN = 3
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wdt_nmi_i,
  input  logic [N_INT-1:0]                      int_evt_i,
  input  logic [N_EXT-1:0]                      ext_pin_i,
  input  logic                                  sample_tick_i,
  input  logic [2*N_EXT-1:0]                    ext_edge_sel_i,
  input  logic [N_EXT-1:0]                      ext_filt_en_i,
  input  logic [N_INT+N_EXT-1:0]                src_en_i,
  input  logic [LVL_W*(N_INT+N_EXT)-1:0]        src_lvl_i,
  input  logic [CUR_W-1:0]                      cpu_lvl_i,
  input  logic                                  ack_i,
  output logic                                  irq_req_o,
  output logic [$clog2(N_INT+N_EXT+1)-1:0]      irq_vec_o
);

  localparam int N_SRC = N_INT + N_EXT;
  localparam int VW    = $clog2(N_SRC + 1);

  logic [N_EXT-1:0] ext_hit;
  logic [N_SRC-1:0] set_vec, clr_vec, pend_q, pend_d;
  logic             nmi_q, nmi_d, nmi_clr;
  logic             arb_req;
  logic [VW-1:0]    arb_vec;

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    prio_intc_ext_cond #(.FILT_LEN(FILT_LEN)) i_cond (
      .clk       (clk),
      .rst       (rst),
      .pin_i     (ext_pin_i[g]),
      .tick_i    (sample_tick_i),
      .filt_en_i (ext_filt_en_i[g]),
      .edge_sel_i(ext_edge_sel_i[2*g +: 2]),
      .hit_o     (ext_hit[g])
    );
  end

  assign set_vec = {ext_hit, int_evt_i};

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      clr_vec[i] = ack_i && irq_req_o && (irq_vec_o == VW'(i + 1));
    end
    nmi_clr = ack_i && irq_req_o && (irq_vec_o == '0);
  end

  // New events win over a clear in the same cycle.
  assign pend_d = (pend_q & ~clr_vec) | set_vec;
  assign nmi_d  = (nmi_q & ~nmi_clr) | wdt_nmi_i;

  prio_intc_arb #(.N_SRC(N_SRC), .VW(VW)) i_arb (
    .pend_i   (pend_d),
    .en_i     (src_en_i),
    .lvl_i    (src_lvl_i),
    .cpu_lvl_i(cpu_lvl_i),
    .nmi_i    (nmi_d),
    .req_o    (arb_req),
    .vec_o    (arb_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      nmi_q     <= 1'b0;
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      pend_q    <= pend_d;
      nmi_q     <= nmi_d;
      irq_req_o <= arb_req;
      irq_vec_o <= arb_vec;
    end
  end

  // ---------------- assertions ----------------
  logic [LVL_W*N_SRC-1:0] lvl_seen_q;
  logic [CUR_W-1:0]       cpu_seen_q;
  logic [CUR_W-1:0]       out_rank;

  always_ff @(posedge clk) begin
    lvl_seen_q <= src_lvl_i;
    cpu_seen_q <= cpu_lvl_i;
  end

  always_comb begin
    out_rank = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (irq_vec_o == VW'(i + 1)) out_rank = {1'b0, lvl_seen_q[LVL_W*i +: LVL_W]} + CUR_W'(1);
    end
  end

  // R7: a pending watchdog event always owns the outputs
  a_r7_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> (irq_req_o && irq_vec_o == '0));

  // R6: a forwarded maskable source outranks the level the core had
  a_r6_above_level: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && irq_vec_o != '0) |-> (out_rank > cpu_seen_q));

  // R8: acknowledging vector 0 without a new watchdog event clears it
  a_r8_nmi_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_req_o && irq_vec_o == '0 && !wdt_nmi_i) |=> !nmi_q);

  // R1: request stays low on the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !irq_req_o);

endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;

  localparam int N_INT = 44;
  localparam int N_EXT = 8;
  localparam int N_SRC = N_INT + N_EXT;
  localparam int VW    = $clog2(N_SRC + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wdt_nmi_i = 1'b0;
  logic [N_INT-1:0]     int_evt_i = '0;
  logic [N_EXT-1:0]     ext_pin_i = '0;
  logic                 sample_tick_i = 1'b0;
  logic [2*N_EXT-1:0]   ext_edge_sel_i = '0;
  logic [N_EXT-1:0]     ext_filt_en_i = '0;
  logic [N_SRC-1:0]     src_en_i = '1;
  logic [2*N_SRC-1:0]   src_lvl_i = '0;
  logic [2:0]           cpu_lvl_i = '0;
  logic                 ack_i = 1'b0;
  logic                 irq_req_o;
  logic [VW-1:0]        irq_vec_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  prio_intc #(.N_INT(N_INT), .N_EXT(N_EXT), .FILT_LEN(3)) i_prio_intc (
    .clk(clk), .rst(rst), .wdt_nmi_i(wdt_nmi_i), .int_evt_i(int_evt_i),
    .ext_pin_i(ext_pin_i), .sample_tick_i(sample_tick_i),
    .ext_edge_sel_i(ext_edge_sel_i), .ext_filt_en_i(ext_filt_en_i),
    .src_en_i(src_en_i), .src_lvl_i(src_lvl_i), .cpu_lvl_i(cpu_lvl_i),
    .ack_i(ack_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
  );

  // sample strobe: one cycle in four
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      sample_tick_i = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic req, input int vec);
    n_vec++;
    if (irq_req_o !== req || (req && irq_vec_o !== VW'(vec))) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irq_req_o, irq_vec_o, req, vec);
    end
  endtask

  task automatic pulse_int(input int k);
    int_evt_i[k] = 1'b1;
    step(1);
    int_evt_i[k] = 1'b0;
  endtask

  task automatic ack_once();
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 64 && irq_req_o; n++) ack_once();
  endtask

  task automatic t_reset();
    expect_out("R1 in reset", 1'b0, 0);
    step(2);
    rst = 1'b0;
    step(1);
    expect_out("R1 after reset", 1'b0, 0);
  endtask

  task automatic t_single();
    pulse_int(5);
    expect_out("R12 same-edge latency", 1'b1, 6);
    expect_out("R2 internal vector", 1'b1, 6);
    ack_once();
    expect_out("R8 cleared", 1'b0, 0);
  endtask

  task automatic t_priority();
    src_lvl_i[2*3 +: 2]  = 2'd0;
    src_lvl_i[2*20 +: 2] = 2'd2;
    int_evt_i[3] = 1'b1; int_evt_i[20] = 1'b1;
    step(1);
    int_evt_i = '0;
    expect_out("R4 higher rank wins", 1'b1, 21);
    ack_once();
    expect_out("R8 next winner after ack", 1'b1, 4);
    ack_once();
    expect_out("R8 all cleared", 1'b0, 0);
    src_lvl_i = '0;
  endtask

  task automatic t_tie();
    src_lvl_i[2*7 +: 2]  = 2'd1;
    src_lvl_i[2*30 +: 2] = 2'd1;
    pulse_int(30);
    expect_out("R5 single first", 1'b1, 31);
    pulse_int(7);
    expect_out("R5 lower index wins tie", 1'b1, 8);
    drain();
    src_lvl_i = '0;
  endtask

  task automatic t_mask();
    src_lvl_i[2*10 +: 2] = 2'd1;
    cpu_lvl_i = 3'd2;
    pulse_int(10);
    step(1);
    expect_out("R6 equal rank blocked", 1'b0, 0);
    cpu_lvl_i = 3'd1;
    step(1);
    expect_out("R6 lower level passes", 1'b1, 11);
    src_lvl_i[2*10 +: 2] = 2'd3;
    cpu_lvl_i = 3'd4;
    step(1);
    expect_out("R6 level 4 blocks all", 1'b0, 0);
    cpu_lvl_i = 3'd0;
    step(1);
    expect_out("R6 released", 1'b1, 11);
    drain();
    src_lvl_i = '0;
  endtask

  task automatic t_enable();
    src_en_i[15] = 1'b0;
    pulse_int(15);
    step(2);
    expect_out("R3 disabled not forwarded", 1'b0, 0);
    src_en_i[15] = 1'b1;
    step(1);
    expect_out("R3 held pending forwarded", 1'b1, 16);
    drain();
  endtask

  task automatic t_nmi();
    cpu_lvl_i = 3'd4;
    src_en_i = '0;
    pulse_int(2);
    wdt_nmi_i = 1'b1;
    step(1);
    wdt_nmi_i = 1'b0;
    expect_out("R7 watchdog wins", 1'b1, 0);
    ack_once();
    expect_out("R7 watchdog cleared", 1'b0, 0);
    cpu_lvl_i = 3'd0;
    src_en_i = '1;
    step(1);
    expect_out("R3 internal after watchdog", 1'b1, 3);
    drain();
  endtask

  task automatic t_ack_race();
    pulse_int(9);
    expect_out("R9 shown", 1'b1, 10);
    ack_i = 1'b1; int_evt_i[9] = 1'b1;
    step(1);
    ack_i = 1'b0; int_evt_i[9] = 1'b0;
    expect_out("R9 re-set on ack cycle", 1'b1, 10);
    ack_once();
    expect_out("R9 second ack clears", 1'b0, 0);
  endtask

  task automatic t_ext_edge();
    int j = 2;
    int v = N_INT + j + 1;
    ext_edge_sel_i[2*j +: 2] = 2'b01;
    ext_pin_i[j] = 1'b1; step(4);
    expect_out("R10 rising taken", 1'b1, v);
    drain();
    ext_pin_i[j] = 1'b0; step(4);
    expect_out("R10 falling ignored on rise", 1'b0, 0);
    ext_edge_sel_i[2*j +: 2] = 2'b10;
    ext_pin_i[j] = 1'b1; step(4);
    expect_out("R10 rising ignored on fall", 1'b0, 0);
    ext_pin_i[j] = 1'b0; step(4);
    expect_out("R10 falling taken", 1'b1, v);
    drain();
    ext_edge_sel_i[2*j +: 2] = 2'b11;
    ext_pin_i[j] = 1'b1; step(4);
    expect_out("R10 both: rise", 1'b1, v);
    drain();
    ext_pin_i[j] = 1'b0; step(4);
    expect_out("R10 both: fall", 1'b1, v);
    drain();
    ext_edge_sel_i[2*j +: 2] = 2'b00;
    ext_pin_i[j] = 1'b1; step(4);
    expect_out("R10 off ignores rise", 1'b0, 0);
    ext_pin_i[j] = 1'b0; step(4);
    expect_out("R10 off ignores fall", 1'b0, 0);
  endtask

  task automatic t_ext_filter();
    int j = 5;
    int v = N_INT + j + 1;
    ext_edge_sel_i[2*j +: 2] = 2'b01;
    ext_filt_en_i[j] = 1'b1;
    step(20);
    ext_pin_i[j] = 1'b1; step(6);
    ext_pin_i[j] = 1'b0; step(20);
    expect_out("R11 short pulse rejected", 1'b0, 0);
    ext_pin_i[j] = 1'b1; step(20);
    expect_out("R11 steady level accepted", 1'b1, v);
    drain();
    ext_pin_i[j] = 1'b0; step(20);
    expect_out("R11 fall not taken on rise", 1'b0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    step(1);
    t_reset();
    t_single();
    t_priority();
    t_tie();
    t_mask();
    t_enable();
    t_nmi();
    t_ack_race();
    t_ext_edge();
    t_ext_filter();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule